// File: doc/BRIEF.md
# Cascaded 32-bit Timer with Merged Capture Inputs

The block is a free-running 32-bit timer built from two 16-bit halves. The lower half advances on each qualified count tick, and the upper half advances only when the lower half rolls over. Each half has its own capture register and its own external capture pin. A merge bit per half adds the other half's pin to that half's capture condition through a logical OR. When both merge bits are set, both capture registers latch on the same event, so software reads one coherent 32-bit timestamp from the two halves.

The capture pins are synchronised before use. For each half, the selected edge (rising, falling or both) is detected on the combined OR signal, not on the pins one by one. While one pin is held high, a transition on the other pin is therefore invisible. Capture events set sticky flags that software clears by writing 1, and a second event before the clear sets an overrun flag. A single-word register port gives read and write access to the counters, the control fields and the flags, and read-only access to the capture registers.

Top module: `cascap_timer`

## Requirements
- R1: The lower counter increments by one on a clock edge where `tick` is 1 and the run bit (CTRL bit 0) is 1. When either is 0, neither counter changes.
- R2: The upper counter increments by one exactly on the edge where the lower counter rolls from FFFFh to 0000h, and on no other counting edge.
- R3: When both halves roll over together (upper FFFFh, lower FFFFh, one count), both become 0000h and FLAGS bit 4 (32-bit wrap) is set.
- R4: Each half has a 2-bit edge select: CTRL[2:1] for the lower half and CTRL[4:3] for the upper half. The encodings are 00 no capture, 01 rising, 10 falling, 11 both edges.
- R5: The capture signal of a half is its own pin, ORed with the other half's pin when its merge bit is set (CTRL bit 5 for the lower half, bit 6 for the upper half). Without the merge bit, the other pin has no effect.
- R6: Edges are detected on the combined signal. A transition on one pin while the other merged pin is high causes no capture.
- R7: A capture writes the half's counter value into its capture register on the third rising clock edge after the pin change. The value written is the counter value held before that edge.
- R8: When a capture and a lower-counter wrap happen on the same edge, the captured pair holds the pre-increment values of both halves.
- R9: A capture sets the half's capture flag (FLAGS bit 0 for the lower half, bit 1 for the upper half). A capture while that flag is still set also sets the half's overrun flag (bit 2 for the lower half, bit 3 for the upper half). Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: Register addresses are: 0 lower counter, 1 upper counter, 2 lower capture, 3 upper capture, 4 CTRL, 5 FLAGS. A write loads on the next clock edge, and a write to a counter takes priority over counting. `reg_rdata` shows the addressed register one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count qualifier |
| cap_pin_lo | input | 1 | Capture pin of the lower half |
| cap_pin_hi | input | 1 | Capture pin of the upper half |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
The bench builds the block with its default 16-bit halves and a two-stage synchroniser. It sweeps every pairing of the two edge selects with all four merge settings. Each pairing is driven through a pin sequence that visits every pin-level transition, including those masked by the other pin. Rollover is reached directly by loading the counters next to FFFFh, so carry, the 32-bit wrap and capture during a wrap are each tested in a handful of cycles.

// File: rtl/cascap_pkg.sv
package cascap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;
endpackage

// File: rtl/cascap_sync.sv
module cascap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/cascap_edge.sv
module cascap_edge
  import cascap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,
  input  edge_sel_e sel,
  output logic      hit
);
  logic prev_q;
  logic rise, fall;

  always_comb begin
    rise = level & ~prev_q;
    fall = ~level & prev_q;
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end
endmodule

// File: rtl/cascap_cascade.sv
module cascap_cascade #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         wrap32
);
  logic [W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic         carry;

  always_comb begin
    carry  = step & (lo_q == {W{1'b1}}) & ~ld_lo;
    wrap32 = carry & (hi_q == {W{1'b1}}) & ~ld_hi;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (ld_lo)      lo_d = ld_val;
    else if (step)  lo_d = lo_q + 1'b1;
    if (ld_hi)      hi_d = ld_val;
    else if (carry) hi_d = hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;
endmodule

// File: rtl/cascap_timer.sv
module cascap_timer
  import cascap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cap_pin_lo,
  input  logic              cap_pin_hi,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);
  localparam int HALVES = 2;

  logic              run_q, run_d;
  logic [1:0]        sel_q [HALVES];
  logic [1:0]        sel_d [HALVES];
  logic [HALVES-1:0] merge_q, merge_d;

  logic [HALVES-1:0] pin_raw, pin_s, comb, hit;
  logic [CNT_W-1:0]  cnt_v [HALVES];
  logic [CNT_W-1:0]  cap_q [HALVES];
  logic [CNT_W-1:0]  cap_d [HALVES];
  logic [HALVES-1:0] capf_q, capf_d, ovrf_q, ovrf_d;
  logic              wrapf_q, wrapf_d;
  logic [CNT_W-1:0]  rdata_q, rdata_d;

  logic step, ld_lo, ld_hi, wr_ctrl, wr_flags, wrap32;
  logic [CNT_W-1:0] cnt_lo, cnt_hi;

  assign step     = tick & run_q;
  assign ld_lo    = reg_we & (reg_addr == A_CNT_LO);
  assign ld_hi    = reg_we & (reg_addr == A_CNT_HI);
  assign wr_ctrl  = reg_we & (reg_addr == A_CTRL);
  assign wr_flags = reg_we & (reg_addr == A_FLAGS);
  assign pin_raw  = {cap_pin_hi, cap_pin_lo};

  cascap_cascade #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_val(reg_wdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .wrap32(wrap32)
  );
  assign cnt_v[0] = cnt_lo;
  assign cnt_v[1] = cnt_hi;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    cascap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[h]), .q(pin_s[h])
    );
    assign comb[h] = pin_s[h] | (merge_q[h] & pin_s[HALVES-1-h]);
    cascap_edge u_edge (
      .clk(clk), .rst_n(rst_n), .level(comb[h]),
      .sel(edge_sel_e'(sel_q[h])), .hit(hit[h])
    );
  end

  always_comb begin
    run_d      = run_q;
    sel_d      = sel_q;
    merge_d    = merge_q;
    if (wr_ctrl) begin
      run_d    = reg_wdata[0];
      sel_d[0] = reg_wdata[2:1];
      sel_d[1] = reg_wdata[4:3];
      merge_d  = reg_wdata[6:5];
    end
    for (int h = 0; h < HALVES; h++) begin
      cap_d[h]  = hit[h] ? cnt_v[h] : cap_q[h];
      capf_d[h] = (capf_q[h] & ~(wr_flags & reg_wdata[h])) | hit[h];
      ovrf_d[h] = (ovrf_q[h] & ~(wr_flags & reg_wdata[2+h])) | (hit[h] & capf_q[h]);
    end
    wrapf_d = (wrapf_q & ~(wr_flags & reg_wdata[4])) | wrap32;
  end

  always_comb begin
    rdata_d = '0;
    unique case (reg_addr)
      A_CNT_LO: rdata_d = cnt_lo;
      A_CNT_HI: rdata_d = cnt_hi;
      A_CAP_LO: rdata_d = cap_q[0];
      A_CAP_HI: rdata_d = cap_q[1];
      A_CTRL:   rdata_d[6:0] = {merge_q, sel_q[1], sel_q[0], run_q};
      A_FLAGS:  rdata_d[4:0] = {wrapf_q, ovrf_q, capf_q};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sel_q   <= '{default: '0};
      merge_q <= '0;
      cap_q   <= '{default: '0};
      capf_q  <= '0;
      ovrf_q  <= '0;
      wrapf_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      sel_q   <= sel_d;
      merge_q <= merge_d;
      cap_q   <= cap_d;
      capf_q  <= capf_d;
      ovrf_q  <= ovrf_d;
      wrapf_q <= wrapf_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/cascap_timer_chk.sv
module cascap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             ld_lo,
  input logic             ld_hi,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi,
  input logic [CNT_W-1:0] cap_lo,
  input logic [1:0]       hit,
  input logic [1:0]       capf,
  input logic [1:0]       ovrf,
  input logic [1:0]       sel_lo
);
  AST_CARRY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_lo && !ld_hi && cnt_lo == {CNT_W{1'b1}}) |=> (cnt_hi == $past(cnt_hi) + 1'b1)); // R2
  AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_hi && !(step && cnt_lo == {CNT_W{1'b1}})) |=> $stable(cnt_hi)); // R2
  AST_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_lo) |=> $stable(cnt_lo)); // R1
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (cap_lo == $past(cnt_lo))); // R7
  AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> capf[0]); // R9
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && capf[1]) |=> ovrf[1]); // R9
  AST_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lo == 2'b00) |-> !hit[0]); // R4
endmodule

bind cascap_timer cascap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .ld_lo(ld_lo), .ld_hi(ld_hi),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_q[0]), .hit(hit),
  .capf(capf_q), .ovrf(ovrf_q), .sel_lo(sel_q[0])
);

// File: tb/cascap_timer_test.sv
module cascap_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        pin_lo = 1'b0;
  logic        pin_hi = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascap_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin_lo(pin_lo),
    .cap_pin_hi(pin_hi), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic edge_hit(input logic [1:0] sel, input logic o, input logic n);
    case (sel)
      2'b01:   return ~o & n;
      2'b10:   return o & ~n;
      2'b11:   return o ^ n;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    logic [15:0] exp_cap [2];
    logic [1:0]  seq [9];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state of every register
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R10 reset", v, 16'h0000);
    end

    // R1 / R2 counting and carry
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'hFFFE);
    wr(3'd1, 16'h0512);
    rd(3'd4, v); check("R10 ctrl readback", v, 16'h0001);
    ticks(3);
    rd(3'd0, v); check("R1 lo after 3 ticks", v, 16'h0001);
    rd(3'd1, v); check("R2 hi after wrap", v, 16'h0513);
    ticks(2);
    rd(3'd1, v); check("R2 hi no carry", v, 16'h0513);
    rd(3'd0, v); check("R1 lo counts", v, 16'h0003);
    wr(3'd4, 16'h0000);
    ticks(5);
    rd(3'd0, v); check("R1 run off lo", v, 16'h0003);
    rd(3'd1, v); check("R1 run off hi", v, 16'h0513);
    rd(3'd5, v); check("R3 wrap flag clear", v, 16'h0000);

    // R3 32-bit wrap
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    wr(3'd4, 16'h0001);
    ticks(1);
    wr(3'd4, 16'h0000);
    rd(3'd0, v); check("R3 lo wrapped", v, 16'h0000);
    rd(3'd1, v); check("R3 hi wrapped", v, 16'h0000);
    rd(3'd5, v); check("R3 wrap flag set", v, 16'h0010);
    wr(3'd5, 16'h0010);
    rd(3'd5, v); check("R9 wrap flag cleared", v, 16'h0000);

    // R7 latency: capture register updates on third edge after pin change
    wr(3'd0, 16'h4321);
    wr(3'd4, 16'h0002);             // lo rising, no merge
    @(negedge clk); addr = 3'd2; pin_lo = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);   // capture lands here
    @(negedge clk); check("R7 not visible yet", rdata, 16'h0000);
    @(negedge clk); check("R7 captured", rdata, 16'h4321);
    @(negedge clk); pin_lo = 1'b0;
    repeat (4) @(negedge clk);
    wr(3'd5, 16'h001F);

    // R4 R5 R6 sweep over selects and merge settings
    seq[0] = 2'b00; seq[1] = 2'b01; seq[2] = 2'b11; seq[3] = 2'b10; seq[4] = 2'b00;
    seq[5] = 2'b10; seq[6] = 2'b11; seq[7] = 2'b01; seq[8] = 2'b00;
    exp_cap[0] = 16'h4321;
    exp_cap[1] = 16'h0000;
    for (int cfg = 0; cfg < 64; cfg++) begin
      logic [1:0] sl, sh, mg;
      sl = 2'(cfg); sh = 2'(cfg >> 2); mg = 2'(cfg >> 4);
      wr(3'd4, {9'd0, mg, sh, sl, 1'b0});
      for (int s = 1; s < 9; s++) begin
        logic [1:0] o, n;
        logic co [2];
        logic cn [2];
        logic hl, hh;
        logic [15:0] vlo, vhi;
        o = seq[s-1]; n = seq[s];
        vlo = 16'h1000 + 16'(cfg * 16 + s);
        vhi = 16'h2000 + 16'(cfg * 16 + s);
        wr(3'd0, vlo);
        wr(3'd1, vhi);
        co[0] = o[0] | (mg[0] & o[1]);  cn[0] = n[0] | (mg[0] & n[1]);
        co[1] = o[1] | (mg[1] & o[0]);  cn[1] = n[1] | (mg[1] & n[0]);
        hl = edge_hit(sl, co[0], cn[0]);
        hh = edge_hit(sh, co[1], cn[1]);
        if (hl) exp_cap[0] = vlo;
        if (hh) exp_cap[1] = vhi;
        @(negedge clk); pin_lo = n[0]; pin_hi = n[1];
        repeat (4) @(negedge clk);
        rd(3'd2, v);  check("R5 R6 lo capture", v, exp_cap[0]);
        rd(3'd3, v2); check("R4 R6 hi capture", v2, exp_cap[1]);
        rd(3'd5, v);  check("R9 capture flags", v, {14'd0, hh, hl});
        wr(3'd5, 16'h001F);
      end
    end

    // R9 overrun and write-one-to-clear
    wr(3'd4, 16'h0002);
    @(negedge clk); pin_lo = 1'b1; repeat (4) @(negedge clk);
    pin_lo = 1'b0; repeat (4) @(negedge clk);
    pin_lo = 1'b1; repeat (4) @(negedge clk);
    pin_lo = 1'b0; repeat (4) @(negedge clk);
    rd(3'd5, v); check("R9 overrun set", v, 16'h0005);
    wr(3'd5, 16'h0000);
    rd(3'd5, v); check("R9 write zero no effect", v, 16'h0005);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); check("R9 clear cap only", v, 16'h0004);
    wr(3'd5, 16'h0004);
    rd(3'd5, v); check("R9 clear overrun", v, 16'h0000);

    // R8 capture on the same edge as a lower wrap
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'h0512);
    wr(3'd4, 16'h006B);             // run, both rising, both merged
    @(negedge clk); pin_lo = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    wr(3'd4, 16'h0000);
    rd(3'd2, v); check("R8 lo pre-increment", v, 16'hFFFF);
    rd(3'd3, v); check("R8 hi pre-increment", v, 16'h0512);
    rd(3'd0, v); check("R8 lo after wrap", v, 16'h0000);
    rd(3'd1, v); check("R8 hi after wrap", v, 16'h0513);
    rd(3'd5, v); check("R8 both flags", v, 16'h0003);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule